// File: doc/BRIEF.md
# Serial EEPROM target with SPI pins

This block models a byte-addressed serial EEPROM that answers as a target on an SPI bus (mode 0). The bus pins, chip select, serial clock, serial data in, serial data out and a pause input, are sampled by a fast system clock. The bus clock must therefore run at least four system clocks per half period. Inside are a byte array whose depth is a parameter, a page buffer for writes, and a status register. The status register carries a write-enable latch, a busy flag, two block-protect bits and a protect-enable bit. A write to the array or to the status register runs as an internal cycle whose length in system clocks is a parameter.

A host selects the part by pulling chip select low and shifts an 8-bit command, then any address and data bytes. All bits are shifted most significant bit first. Reads stream bytes for as long as the clock runs. A write first collects bytes in the page buffer. It reaches the array only if chip select rises exactly on a byte boundary, and only after an earlier frame has set the write-enable latch. The pause input freezes a transfer in the middle of a byte so that another target can use the shared clock.

Top module: `eep_spi_top`

## Requirements
- R1: `so_en` is low one system clock after `cs_n` is high, and one system clock after `hold_n` is low. It is high only while a read or status byte is being shifted out.
- R2: Serial input is sampled on rising SCK edges from the first rising edge after `cs_n` falls, most significant bit first. `so` changes only after falling SCK edges, also most significant bit first. Command codes: 03h read, 02h write, 04h clear latch, 06h set latch, 05h read status, 01h write status.
- R3: A read is command 03h, then a 16-bit address, then a stream of data bytes. The top address bit is ignored. Each byte comes from the address following the previous one.
- R4: During a read, the address that follows 7FFFh is 0000h.
- R5: Command 06h sets the latch (status bit 1) only when `cs_n` rises right after its eighth bit. Any further bit in the same frame leaves the latch unchanged, including a following write command. Command 04h clears the latch under the same rule.
- R6: A write command issued while the latch is clear changes neither the array nor the busy flag.
- R7: Write data goes to consecutive byte positions within one 64-byte page, starting at the address offset. Past the last position it wraps to the start of the same page, and a later byte replaces an earlier one at the same position.
- R8: The array is updated only when `cs_n` rises after at least one whole data byte and on a byte boundary. A rise after an address only, or in the middle of a byte, starts no cycle.
- R9: A committed write holds the busy flag (status bit 0) high for exactly T_WRITE system clocks, with the latch held high. During the cycle, status reads are served and every other command is ignored, with `so_en` kept low. At the end, busy and the latch clear together.
- R10: Status layout: bit 7 protect-enable, bit 3 and bit 2 block-protect, bit 1 latch, bit 0 busy, other bits zero, all zero after reset. Command 01h with one data byte needs the latch set and updates only bits 7, 3 and 2 through an internal cycle.
- R11: While `hold_n` is low, SCK and SI are ignored. After release, the transfer continues with the next bit as if no pause had happened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data to host |
| so_en | output | 1 | Output enable for the `so` pad driver |

## Verification
The hardest state to reach from the pins is a command that arrives while the internal write cycle is still running. The bench commits a page write and, in the next frames, immediately polls status and issues an array read. It then checks that the busy and latch bits are both set and that the data pin stays disabled. The cycle length is chosen so that both frames fit inside it. The pause case is reached by dropping `hold_n` mid-byte with the clock high, toggling SCK and SI while paused, and restoring the clock level before release. Garbage bits that slipped through would show up as a corrupted data byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  localparam int ADDR_BITS = 15;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_AHI,
    ST_ALO,
    ST_RDATA,
    ST_WDATA,
    ST_STAT,
    ST_SRDATA,
    ST_SRDONE,
    ST_SETWEL,
    ST_CLRWEL,
    ST_SKIP
  } frame_st_t;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic si_q,
  output logic cs_q,
  output logic hold_q
);
  logic sck_q, sck_d, cs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      sck_d  <= 1'b0;
      cs_q   <= 1'b1;
      cs_d   <= 1'b1;
      si_q   <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      sck_q  <= sck;
      sck_d  <= sck_q;
      cs_q   <= cs_n;
      cs_d   <= cs_q;
      si_q   <= si;
      hold_q <= hold_n;
    end
  end

  // clock edges count only while selected and not paused; select edges always count
  logic live;
  assign live     = hold_q & ~cs_q;
  assign sck_rise = live & sck_q & ~sck_d;
  assign sck_fall = live & ~sck_q & sck_d;
  assign cs_fall  = ~cs_q & cs_d;
  assign cs_rise  = cs_q & ~cs_d;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int DEPTH = 4096,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int PIW        = $clog2(PAGE_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [PIW-1:0] load_idx,
  input  logic           push,
  input  logic [7:0]     push_data,
  input  logic [PIW-1:0] rd_idx,
  output logic [7:0]     rd_data,
  output logic           rd_mask
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [PIW-1:0]        ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr    <= '0;
    end else if (load) begin
      mask_q <= '0;
      ptr    <= load_idx;
    end else if (push) begin
      mask_q[ptr] <= 1'b1;
      ptr         <= ptr + 1'b1;   // wraps inside the page
    end
  end

  always_ff @(posedge clk) begin
    if (push) data_q[ptr] <= push_data;
  end

  assign rd_data = data_q[rd_idx];
  assign rd_mask = mask_q[rd_idx];
endmodule

// File: rtl/eep_spi_top.sv
module eep_spi_top
  import eep_pkg::*;
#(
  parameter int MEM_BYTES  = 4096,
  parameter int PAGE_BYTES = 64,
  parameter int T_WRITE    = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic so,
  output logic so_en
);
  localparam int IDX_W = $clog2(MEM_BYTES);
  localparam int PIW   = $clog2(PAGE_BYTES);
  localparam int WCW   = $clog2(T_WRITE + 1);
  localparam logic [WCW-1:0] WC_LAST = WCW'(T_WRITE - 1);
  localparam logic [WCW-1:0] WC_PAGE = WCW'(PAGE_BYTES);

  logic sck_rise, sck_fall, cs_fall, cs_rise, si_q, cs_q, hold_q;

  eep_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .si_q(si_q), .cs_q(cs_q), .hold_q(hold_q)
  );

  frame_st_t            state;
  logic [2:0]           bitcnt;
  logic [7:0]           shreg;
  logic [ADDR_BITS-1:0] addr;
  logic                 is_read, wel, wip, wr_stat, got_byte, so_q;
  logic [2:0]           sr_keep, sr_new;
  logic [WCW-1:0]       wcnt;
  logic [7:0]           out_byte, status, rd_data, pb_data;
  logic                 pb_mask, mem_we, pb_load, pb_push, bit_in, byte_end, out_phase;

  assign bit_in    = sck_rise & ~cs_fall;
  assign byte_end  = bit_in & (bitcnt == 3'd7);
  assign pb_load   = byte_end & (state == ST_ALO) & ~is_read;
  assign pb_push   = byte_end & (state == ST_WDATA);
  assign status    = {sr_keep[2], 3'b000, sr_keep[1:0], wel, wip};
  assign out_phase = (state == ST_RDATA) | (state == ST_STAT);
  assign mem_we    = wip & ~wr_stat & (wcnt < WC_PAGE) & pb_mask;
  assign so        = so_q;
  assign so_en     = ~cs_q & hold_q & out_phase;

  logic [7:0] byte_in;
  assign byte_in = {shreg[6:0], si_q};

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
    .clk(clk), .rst_n(rst_n),
    .load(pb_load), .load_idx(byte_in[PIW-1:0]),
    .push(pb_push), .push_data(byte_in),
    .rd_idx(wcnt[PIW-1:0]), .rd_data(pb_data), .rd_mask(pb_mask)
  );

  eep_array #(.DEPTH(MEM_BYTES)) u_mem (
    .clk(clk), .we(mem_we),
    .waddr({addr[IDX_W-1:PIW], wcnt[PIW-1:0]}), .wdata(pb_data),
    .raddr(addr[IDX_W-1:0]), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      addr     <= '0;
      is_read  <= 1'b0;
      wel      <= 1'b0;
      wip      <= 1'b0;
      wr_stat  <= 1'b0;
      got_byte <= 1'b0;
      sr_keep  <= '0;
      sr_new   <= '0;
      wcnt     <= '0;
      so_q     <= 1'b0;
      out_byte <= '0;
    end else begin
      // internal write cycle timer
      if (wip) begin
        wcnt <= wcnt + 1'b1;
        if (wcnt == WC_LAST) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end
      end

      if (cs_fall) begin
        state  <= ST_CMD;
        bitcnt <= '0;
      end else if (cs_rise) begin
        if (bitcnt == 3'd0) begin
          case (state)
            ST_SETWEL: wel <= 1'b1;
            ST_CLRWEL: wel <= 1'b0;
            ST_WDATA: if (got_byte) begin
              wip     <= 1'b1;
              wcnt    <= '0;
              wr_stat <= 1'b0;
            end
            ST_SRDONE: begin
              wip     <= 1'b1;
              wcnt    <= '0;
              wr_stat <= 1'b1;
              sr_keep <= sr_new;
            end
            default: ;
          endcase
        end
        state <= ST_IDLE;
      end else if (bit_in) begin
        bitcnt <= bitcnt + 1'b1;
        shreg  <= byte_in;
        if (bitcnt == 3'd7) begin
          case (state)
            ST_CMD: begin
              if (wip) begin
                state <= (byte_in == OP_RDSR) ? ST_STAT : ST_SKIP;
              end else begin
                case (byte_in)
                  OP_READ: begin
                    is_read <= 1'b1;
                    state   <= ST_AHI;
                  end
                  OP_WRITE: begin
                    is_read <= 1'b0;
                    state   <= wel ? ST_AHI : ST_SKIP;
                  end
                  OP_RDSR: state <= ST_STAT;
                  OP_WREN: state <= ST_SETWEL;
                  OP_WRDI: state <= ST_CLRWEL;
                  OP_WRSR: state <= wel ? ST_SRDATA : ST_SKIP;
                  default: state <= ST_SKIP;
                endcase
              end
            end
            ST_AHI: begin
              addr[ADDR_BITS-1:8] <= byte_in[ADDR_BITS-9:0];
              state               <= ST_ALO;
            end
            ST_ALO: begin
              addr[7:0] <= byte_in;
              got_byte  <= 1'b0;
              state     <= is_read ? ST_RDATA : ST_WDATA;
            end
            ST_RDATA:  addr <= addr + 1'b1;
            ST_WDATA:  got_byte <= 1'b1;
            ST_SRDATA: begin
              sr_new <= {byte_in[7], byte_in[3:2]};
              state  <= ST_SRDONE;
            end
            ST_SETWEL, ST_CLRWEL, ST_SRDONE: state <= ST_SKIP;
            default: ;
          endcase
        end
      end

      // serial output, launched after falling clock edges
      if (sck_fall && out_phase) begin
        if (bitcnt == 3'd0) begin
          out_byte <= (state == ST_STAT) ? status : rd_data;
          so_q     <= (state == ST_STAT) ? status[7] : rd_data[7];
        end else begin
          so_q <= out_byte[~bitcnt];
        end
      end
    end
  end
endmodule

// File: rtl/eep_spi_chk.sv
module eep_spi_chk #(
  parameter int T_WRITE = 400
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       hold_n,
  input logic       so_en,
  input logic       wip,
  input logic       wel,
  input logic       mem_we,
  input logic       cs_q,
  input logic       hold_q,
  input logic [2:0] bitcnt
);
  int run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else        run <= wip ? run + 1 : 0;
  end

  a_r1_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_en);

  a_r1_off_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> !so_en);

  a_r11_hold_freezes_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !cs_q && $past(!cs_q)) |=> $stable(bitcnt));

  a_r9_array_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip);

  a_r9_latch_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> wel);

  a_r9_latch_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  a_r9_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> run == T_WRITE);
endmodule

bind eep_spi_top eep_spi_chk #(.T_WRITE(T_WRITE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_en(so_en),
  .wip(wip), .wel(wel), .mem_we(mem_we), .cs_q(cs_q), .hold_q(hold_q),
  .bitcnt(bitcnt)
);

// File: tb/eep_spi_top_tb.sv
module eep_spi_top_tb;
  localparam int MEM  = 4096;
  localparam int TW   = 600;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_en;

  always #4 clk = ~clk;

  eep_spi_top #(.MEM_BYTES(MEM), .PAGE_BYTES(64), .T_WRITE(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_en(so_en)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [int];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] rx_val;
  event       rx_ev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", rx_val, 0);
    else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rx_val == e, t, rx_val, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int mkey(input int a);
    return (a & 32'h7FFF) % MEM;
  endfunction

  function automatic logic [7:0] dval(input int seed, input int i);
    return 8'((seed + i * 37) & 255);
  endfunction

  task automatic cs_lo();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic cs_hi();
    sck = 1'b0;
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic xbit(input logic b, output logic r);
    si  = b;
    sck = 1'b0;
    tick(HALF);
    r   = so;
    sck = 1'b1;
    tick(HALF);
  endtask

  // hb: bit index after which a pause is inserted, -1 for none
  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input int hb);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      xbit(tx[i], r);
      rx[i] = r;
      if (hb == 7 - i) begin
        hold_n = 1'b0;
        tick(2);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b0; si = ~si; tick(HALF);
          sck = 1'b1; si = ~si; tick(HALF);
        end
        chk(so_en == 1'b0, "R1 so_en low in hold", so_en, 0);
        hold_n = 1'b1;
        tick(2);
      end
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx;
    cs_lo();
    xbyte(op, rx, -1);
    cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] rx;
    cs_lo();
    xbyte(8'h05, rx, -1);
    xbyte(8'h00, st, -1);
    cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int k = 0; k < 40; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  // write frame; commit selects whether the model expects the array to change
  task automatic write_frame(input int a, input int n, input int seed, input bit commit);
    logic [7:0] rx;
    cs_lo();
    xbyte(8'h02, rx, -1);
    xbyte(8'(a >> 8), rx, -1);
    xbyte(8'(a), rx, -1);
    for (int i = 0; i < n; i++) begin
      xbyte(dval(seed, i), rx, -1);
      if (commit) model[mkey((a & ~63) | ((a + i) & 63))] = dval(seed, i);
    end
    cs_hi();
  endtask

  task automatic write_ok(input int a, input int n, input int seed);
    cmd(8'h06);
    write_frame(a, n, seed, 1'b1);
    wait_idle();
  endtask

  task automatic read_chk(input int a, input int n, input string tag, input int hold_byte);
    logic [7:0] rx;
    cs_lo();
    xbyte(8'h03, rx, -1);
    xbyte(8'(a >> 8), rx, -1);
    xbyte(8'(a), rx, -1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[mkey(a + i)]);
      tag_q.push_back(tag);
      xbyte(8'h00, rx, (i == hold_byte) ? 3 : -1);
      rx_val = rx;
      -> rx_ev;
      tick(1);
    end
    cs_hi();
  endtask

  initial begin
    logic [7:0] st, rx;
    tick(5);
    rst_n = 1'b1;
    tick(4);

    // reset state
    chk(so_en == 1'b0, "R1 so_en after reset", so_en, 0);
    rdsr(st);
    chk(st == 8'h00, "R10 status after reset", st, 8'h00);

    // R5 latch set and clear
    cmd(8'h06);
    rdsr(st);
    chk(st == 8'h02, "R5 latch set by 06h", st, 8'h02);
    cmd(8'h04);
    rdsr(st);
    chk(st == 8'h00, "R5 latch cleared by 04h", st, 8'h00);

    // R3/R2 basic single byte write and read
    write_ok(16'h0010, 1, 8'hA5);
    read_chk(16'h0010, 1, "R2 R3 single byte read", -1);

    // R6 write without latch
    write_frame(16'h0010, 1, 8'h3C, 1'b0);
    rdsr(st);
    chk(st[0] == 1'b0, "R6 no busy without latch", st, 0);
    read_chk(16'h0010, 1, "R6 array unchanged", -1);

    // R5 set-latch followed by write command in same frame
    cs_lo();
    xbyte(8'h06, rx, -1);
    xbyte(8'h02, rx, -1);
    cs_hi();
    rdsr(st);
    chk(st == 8'h00, "R5 latch not set with extra bits", st, 8'h00);

    // R3 multi-byte page write, sequential read
    write_ok(16'h0100, 4, 8'h11);
    read_chk(16'h0100, 4, "R3 sequential read", -1);

    // R7 page wrap
    write_ok(16'h01FE, 4, 8'h40);
    read_chk(16'h01C0, 2, "R7 wrap to page start", -1);
    read_chk(16'h01FE, 2, "R7 bytes at page end", -1);

    // R7 overwrite of earlier buffered bytes
    write_ok(16'h0240, 66, 8'h07);
    read_chk(16'h0240, 3, "R7 later byte replaces earlier", -1);

    // R8 aborts
    write_ok(16'h0300, 1, 8'h5A);
    cmd(8'h06);
    cs_lo();
    xbyte(8'h02, rx, -1);
    xbyte(8'h03, rx, -1);
    xbyte(8'h00, rx, -1);
    xbyte(8'h77, rx, -1);
    for (int i = 0; i < 4; i++) begin
      logic r;
      xbit(1'b1, r);
    end
    cs_hi();
    rdsr(st);
    chk(st[0] == 1'b0, "R8 no cycle after mid-byte rise", st[0], 0);
    cs_lo();
    xbyte(8'h02, rx, -1);
    xbyte(8'h03, rx, -1);
    xbyte(8'h00, rx, -1);
    cs_hi();
    rdsr(st);
    chk(st[0] == 1'b0, "R8 no cycle after address only", st[0], 0);
    read_chk(16'h0300, 1, "R8 array kept after abort", -1);
    cmd(8'h04);

    // R9 commands during the internal cycle
    cmd(8'h06);
    write_frame(16'h0400, 2, 8'h90, 1'b1);
    rdsr(st);
    chk(st[1:0] == 2'b11, "R9 busy and latch during cycle", st[1:0], 3);
    cs_lo();
    xbyte(8'h03, rx, -1);
    xbyte(8'h04, rx, -1);
    xbyte(8'h00, rx, -1);
    begin
      logic r;
      xbit(1'b0, r);
    end
    chk(so_en == 1'b0, "R9 array read refused while busy", so_en, 0);
    cs_hi();
    wait_idle();
    rdsr(st);
    chk(st == 8'h00, "R9 busy and latch cleared at end", st, 8'h00);
    read_chk(16'h0400, 2, "R8 committed data", -1);

    // R4 rollover and ignored top address bit
    write_ok(16'h7FFF, 1, 8'h11);
    write_ok(16'h0000, 1, 8'h22);
    read_chk(16'h7FFF, 2, "R4 read rolls over to 0000h", -1);
    read_chk(16'hFFFF, 1, "R3 top address bit ignored", -1);

    // R11 pause in the middle of a byte
    read_chk(16'h0100, 4, "R11 read resumes after hold", 1);

    // R10 status write
    cmd(8'h06);
    cs_lo();
    xbyte(8'h01, rx, -1);
    xbyte(8'hFF, rx, -1);
    cs_hi();
    wait_idle();
    rdsr(st);
    chk(st == 8'h8C, "R10 status write keeps bits 7 3 2", st, 8'h8C);
    cs_lo();
    xbyte(8'h01, rx, -1);
    xbyte(8'h00, rx, -1);
    cs_hi();
    wait_idle();
    rdsr(st);
    chk(st == 8'h8C, "R10 status write needs latch", st, 8'h8C);
    cmd(8'h06);
    cs_lo();
    xbyte(8'h01, rx, -1);
    xbyte(8'h00, rx, -1);
    cs_hi();
    wait_idle();
    rdsr(st);
    chk(st == 8'h00, "R10 status cleared", st, 8'h00);

    tick(2);
    chk(so_en == 1'b0, "R1 so_en off when deselected", so_en, 0);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_up();
  end
endmodule